// File: doc/BRIEF.md
# Slot-Interval Capture with Overflow and Stall Flags

This block times the gap between successive slots of a slotted disk on a motor shaft, as seen by an optical detector. The raw detector level is brought into the clock domain, its rising transitions are turned into single-cycle events, and a free-running prescaler produces a coarse timebase tick. An interval counter advances once per tick and is latched into the output on every qualified slot event. The capture pulse is the trigger for a downstream speed loop, which converts the interval to shaft speed (with 30 slots per revolution, revolutions per minute equal 2 divided by the interval in seconds).

With the default settings a tick lasts 1024 clock cycles (10.24 µs at 100 MHz). A 1 ms interval at top speed is then about 98 ticks, roughly 1% resolution, and a 30 ms interval at the slowest normal speed fits easily in a 16-bit count. Two guards keep bogus numbers away from the loop. When the counter saturates before the next slot arrives, an overflow flag rises and that interval is discarded. When no slot arrives within a stall timeout (default 6350 ticks, about 65 ms), a stall flag rises. The stall flag stays up until two fresh slots have been seen, because the first slot only restarts timing.

Top module: `slot_interval_capture`

## Requirements
- R1: While reset is asserted and right after it, `stall_o` is 1 and `ovf_o`, `sample_o` and `interval_o` are 0.
- R2: The detector input is synchronised. Only a low-to-high transition counts as a slot, and it takes effect at the third rising clock edge after the input rises, given that the input holds each level for at least two cycles.
- R3: The timebase ticks on every TICK_DIV-th rising clock edge after reset release (edges TICK_DIV, 2·TICK_DIV, and so on). A tick that falls on the same edge as a slot is not counted.
- R4: A valid capture loads `interval_o` with the number of ticks that fell strictly between the previous slot and this one, and raises `sample_o` for exactly one cycle. `interval_o` changes only together with `sample_o`.
- R5: The first slot after reset, and the first slot after a stall, produce no sample. They only restart the interval count.
- R6: `stall_o` falls only at a valid capture, and is 0 whenever `sample_o` is 1.
- R7: The count saturates at 2^CNT_W−1. `ovf_o` rises after that many ticks without a slot and stays up until the next slot. That slot produces no sample and restarts the count, and the stall state is left as it was.
- R8: After STALL_TICKS ticks without a slot while timing is active, `stall_o` rises and `ovf_o` clears. The next slot then behaves as described in R5.
- R9: A sampled interval is always below 2^CNT_W−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_i | input | 1 | Raw optical slot detector level |
| interval_o | output | CNT_W | Last valid interval, in timebase ticks |
| sample_o | output | 1 | One-cycle pulse when a new interval is captured |
| ovf_o | output | 1 | Interval counter saturated before a slot arrived |
| stall_o | output | 1 | No valid speed data (reset, timeout, or re-arming) |

## Verification
The bench uses a 4-cycle tick, a 6-bit counter and a 100-tick timeout. It sweeps slot gaps that step by an odd number of cycles, so the slot falls at every phase of the prescaler. A design that counts the coinciding tick, or that starts timing one edge late, gives intervals off by one at some phases. Gaps are also walked one cycle at a time across the saturation point and across the timeout. These walks catch a flag raised one tick early or late, a saturated interval that still produces a sample, and a timeout that wins over a slot on the same edge. Other runs let the timeout expire after a single re-arming slot and let the counter overflow during the armed state. A design that left stall on the first slot, or cleared it on an overflowed slot, fails those runs.

// File: rtl/slotcap_pkg.sv
`timescale 1ns/1ps
package slotcap_pkg;

    // Timing state of the capture block
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,   // stalled, waiting for a reference slot
        MODE_ARMED = 2'd1,   // stalled, reference slot seen, timing
        MODE_RUN   = 2'd2    // valid data flowing
    } slotcap_mode_e;

    // Register width able to hold values 0 .. n-1 (at least one bit)
    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/slotcap_sync_edge.sv
`timescale 1ns/1ps
module slotcap_sync_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_i,
    output logic rise_o
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[TOP-1:0], enc_i};
        s_d.prev  = s_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.chain[TOP] & ~s_q.prev;

endmodule

// File: rtl/slotcap_timebase.sv
`timescale 1ns/1ps
module slotcap_timebase #(
    parameter int unsigned TICK_DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned   PW   = slotcap_pkg::width_for(TICK_DIV);
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.pre == LAST) s_d.pre = '0;
        else                 s_d.pre = s_q.pre + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = (s_q.pre == LAST);

endmodule

// File: rtl/slotcap_stall_timer.sv
`timescale 1ns/1ps
module slotcap_stall_timer #(
    parameter int unsigned STALL_TICKS = 6350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rise_i,
    input  logic active_i,
    output logic timeout_o
);
    localparam int unsigned   TW  = slotcap_pkg::width_for(STALL_TICKS);
    localparam logic [TW-1:0] LIM = TW'(STALL_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
    } st_state_t;

    st_state_t s_d, s_q;

    // a slot on the same edge always wins over the timeout
    assign timeout_o = tick_i & active_i & ~rise_i & (s_q.tmr == LIM);

    always_comb begin
        s_d = s_q;
        if (rise_i || timeout_o)      s_d.tmr = '0;
        else if (tick_i && active_i)  s_d.tmr = s_q.tmr + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/slotcap_interval_ctr.sv
`timescale 1ns/1ps
module slotcap_interval_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] SAT  = '1;
    localparam logic [CNT_W-1:0] NEAR = SAT - CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ic_state_t;

    ic_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end else if (tick_i && active_i && (s_q.cnt != SAT)) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == NEAR) s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign ovf_o = s_q.ovf;

endmodule

// File: rtl/slot_interval_capture.sv
`timescale 1ns/1ps
module slot_interval_capture
    import slotcap_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 1024,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned STALL_TICKS = 6350
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_i,
    output logic [CNT_W-1:0] interval_o,
    output logic             sample_o,
    output logic             ovf_o,
    output logic             stall_o
);
    typedef struct packed {
        slotcap_mode_e    mode;
        logic [CNT_W-1:0] interval;
        logic             sample;
    } top_state_t;

    top_state_t       s_d, s_q;
    logic             rise, tick, timeout, active, ovf;
    logic [CNT_W-1:0] cnt;

    assign active = (s_q.mode != MODE_IDLE);

    slotcap_sync_edge #(.SYNC_STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .enc_i  (enc_i),
        .rise_o (rise)
    );

    slotcap_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    slotcap_stall_timer #(.STALL_TICKS(STALL_TICKS)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .rise_i    (rise),
        .active_i  (active),
        .timeout_o (timeout)
    );

    slotcap_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .active_i (active),
        .clear_i  (rise | timeout),
        .cnt_o    (cnt),
        .ovf_o    (ovf)
    );

    always_comb begin
        s_d        = s_q;
        s_d.sample = 1'b0;
        if (rise) begin
            case (s_q.mode)
                MODE_IDLE: s_d.mode = MODE_ARMED;   // reference slot only
                default: begin
                    if (!ovf) begin                 // saturated gap is dropped
                        s_d.sample   = 1'b1;
                        s_d.interval = cnt;
                        s_d.mode     = MODE_RUN;
                    end
                end
            endcase
        end else if (timeout) begin
            s_d.mode = MODE_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_IDLE, interval: '0, sample: 1'b0};
        else        s_q <= s_d;
    end

    assign interval_o = s_q.interval;
    assign sample_o   = s_q.sample;
    assign ovf_o      = ovf;
    assign stall_o    = (s_q.mode != MODE_RUN);

endmodule

// File: rtl/slotcap_checker.sv
`timescale 1ns/1ps
module slotcap_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] interval_o,
    input logic             sample_o,
    input logic             ovf_o,
    input logic             stall_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    a_r6_sample_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !stall_o);

    a_r6_stall_drops_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> sample_o);

    a_r4_interval_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_o |-> $stable(interval_o));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

    a_r7_no_sample_after_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !$past(ovf_o));

    a_r9_sample_below_sat: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (interval_o != SAT));

endmodule

bind slot_interval_capture slotcap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .interval_o (interval_o),
    .sample_o   (sample_o),
    .ovf_o      (ovf_o),
    .stall_o    (stall_o)
);

// File: tb/sim_slot_interval_capture.sv
`timescale 1ns/1ps
module sim_slot_interval_capture;
    localparam int P    = 4;
    localparam int W    = 6;
    localparam int ST   = 100;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enc = 1'b0;
    logic [W-1:0] interval;
    logic         sample, ovf, stall;

    int  cyc = 0;
    int  n_cmp = 0, n_bad = 0;
    int  pend_e = -1, last_e = 0, mode = 0, last_val = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    slot_interval_capture #(.TICK_DIV(P), .CNT_W(W), .STALL_TICKS(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .enc_i(enc),
        .interval_o(interval), .sample_o(sample), .ovf_o(ovf), .stall_o(stall)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // one cycle: model from the requirements, then compare at the negedge
    task automatic step();
        int tk;
        int exp_s;
        @(negedge clk);
        exp_s = 0;
        if (cyc == pend_e) begin
            tk = (cyc - 1) / P - last_e / P;           // R3: ticks strictly between slots
            if (mode != 0 && tk >= ST) mode = 0;       // R8: timed out before this slot
            if (mode == 0) mode = 1;                   // R5: reference slot only
            else if (tk < MAXV) begin                  // R7: saturated gap is dropped
                exp_s = 1; last_val = tk; mode = 2;
            end
            last_e = cyc;
        end
        tk = cyc / P - last_e / P;
        if (mode != 0 && tk >= ST) mode = 0;
        chk("R2 R4 R5 sample", int'(sample), exp_s);
        chk("R3 R4 interval", int'(interval), last_val);
        chk("R7 R8 overflow flag", int'(ovf), (mode != 0 && tk >= MAXV) ? 1 : 0);
        chk("R6 R8 stall flag", int'(stall), (mode != 2) ? 1 : 0);
        if (sample) chk("R9 sampled below saturation", (int'(interval) < MAXV) ? 1 : 0, 1);
    endtask

    // raise the detector for three cycles, next slot gap cycles later
    task automatic slot(input int gap);
        enc = 1'b1;
        pend_e = cyc + 3;
        for (int k = 0; k < gap; k++) begin
            step();
            if (k == 2) enc = 1'b0;
        end
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            chk("R1 reset stall", int'(stall), 1);
            chk("R1 reset overflow", int'(ovf), 0);
            chk("R1 reset sample", int'(sample), 0);
            chk("R1 reset interval", int'(interval), 0);
        end
        rst_n = 1'b1;
        repeat (7) step();
        slot(20);                                          // R5 arming slot
        for (int i = 0; i < 30; i++) slot(9 + 7 * i);      // R4 phase sweep
        for (int g = 246; g <= 258; g++) slot(g);          // R7 saturation edge
        slot(40);
        for (int g = 394; g <= 406; g++) slot(g);          // R8 timeout edge
        slot(30);
        slot(450);                                          // R8 timeout in run
        slot(480);                                          // R8 timeout while armed
        slot(300);                                          // R7 overflow while armed
        slot(25);
        slot(30);
        slot(300);                                          // R7 overflow in run
        slot(33);
        repeat (10) step();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule